// File: doc/BRIEF.md
# AES Key Schedule Unit

This block expands a 128-, 192- or 256-bit AES cipher key into the full round-key schedule. It produces one 32-bit word per clock and presents each word on a stream port with its index. When the expansion finishes, the block also holds a 256-bit decryption start key. This key is built from the trailing words of the schedule, so that a decryption datapath can run the schedule backwards, one round at a time.

A single-cycle start request latches the key and the size code. The block then emits the whole schedule, the cipher key words first. One cycle after the last word it pulses done. While an expansion is running, all further requests are ignored.

Top module: `aes_key_sched`

## Requirements
- R1: The size code selects the key length: 0 gives 4 key words and a 44-word schedule, 1 gives 6 key words and 52 words, 2 gives 8 key words and 60 words. A start with code 3 is ignored: no word is produced, done does not pulse and the decryption key is unchanged.
- R2: The key input is left-aligned and big-endian. Key word j is bits [255-32j : 224-32j], and bit 255 is the most significant bit of the first key byte. The first Nk stream words are the key words themselves. Key bits beyond the selected length are ignored.
- R3: For a word index i of at least Nk, the word is word i-Nk XOR a term. When i mod Nk is 0, the term is the previous word rotated left by one byte, passed bytewise through the AES S-box, and XORed with the round constant in its most significant byte. Otherwise the term is the previous word.
- R4: For 256-bit keys only, when i mod 8 is 4, the term is the previous word passed bytewise through the S-box, with no rotation and no constant.
- R5: The round constant starts at 01 and is doubled in GF(2^8), with reduction polynomial 0x11B, after each use: 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36.
- R6: A start accepted at clock edge 0 makes word k appear with ks_valid high and ks_index equal to k after edge k+1. The words come on consecutive cycles in increasing index order.
- R7: done is high for exactly one cycle: the cycle that follows the cycle showing the last word.
- R8: The decryption key is built from 32-bit slots, slot 0 in bits [255:224]. For code 0 it is words 40..43 followed by 128 zero bits. For code 1 it is words 48..51, then 46, 47, then 64 zero bits. For code 2 it is words 56..59, then 52..55. It is cleared when a start is accepted, is complete when done rises, and holds until the next accepted start.
- R9: A start request, together with its key and size, is ignored while an expansion is in progress. Only the first expansion's words appear, and nothing follows its done pulse.
- R10: After reset, ks_valid, done and dec_key are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to expand the key, one cycle |
| key_size | input | 2 | Key length code (0/1/2) |
| key | input | 256 | Left-aligned big-endian cipher key |
| ks_valid | output | 1 | A schedule word is present |
| ks_index | output | 6 | Index of the present word |
| ks_word | output | 32 | Schedule word |
| dec_key | output | 256 | Decryption start key |
| done | output | 1 | One-cycle end-of-expansion pulse |

## Verification
The bench takes the clock edge that accepts a start as edge 0. It expects word k on the stream after edge k+1, and it samples at the falling edge that follows that edge. For a schedule of N words, done and the complete decryption key are due after edge N+1, and done must be low again one cycle later. Every expected word comes from a reference expansion in the bench, whose S-box is generated by a different method from the one in the design. Requests that must be ignored are then followed for several cycles to confirm that the stream stays silent and the decryption key does not move.

// File: rtl/aes_ks_pkg.sv
// Shared constants, the key-size code and the GF(2^8) helpers for the key
// schedule unit. Assumes 32-bit words and up to eight key words.
package aes_ks_pkg;

    localparam int KS_BYTE_W    = 8;
    localparam int KS_WORD_W    = 4 * KS_BYTE_W;
    localparam int KS_MAX_NK    = 8;
    localparam int KS_KEY_W     = KS_WORD_W * KS_MAX_NK;
    localparam int KS_MAX_WORDS = 4 * (KS_MAX_NK + 7);
    localparam int KS_IDX_W     = $clog2(KS_MAX_WORDS);
    localparam int KS_PH_W      = $clog2(KS_MAX_NK);
    localparam int KS_SLOTS     = KS_MAX_NK;
    localparam int KS_LEAD      = 4;

    typedef enum logic [1:0] {
        KSZ_128 = 2'd0,
        KSZ_192 = 2'd1,
        KSZ_256 = 2'd2,
        KSZ_BAD = 2'd3
    } ksz_e;

    // Number of key words for a size code.
    function automatic logic [KS_IDX_W-1:0] ks_nk(input logic [1:0] sz);
        case (sz)
            2'd1:    return KS_IDX_W'(6);
            2'd2:    return KS_IDX_W'(8);
            default: return KS_IDX_W'(4);
        endcase
    endfunction

    // Total schedule words for a size code.
    function automatic logic [KS_IDX_W-1:0] ks_total(input logic [1:0] sz);
        return KS_IDX_W'(4) * (ks_nk(sz) + KS_IDX_W'(7));
    endfunction

    // Multiply by x modulo 0x11B.
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // General GF(2^8) product, shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 through an addition chain; maps 0 to 0.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] a2, a3, a6, a12, a15, a30, a60, a120, a240, a252;
        a2   = gf_mul(a, a);
        a3   = gf_mul(a2, a);
        a6   = gf_mul(a3, a3);
        a12  = gf_mul(a6, a6);
        a15  = gf_mul(a12, a3);
        a30  = gf_mul(a15, a15);
        a60  = gf_mul(a30, a30);
        a120 = gf_mul(a60, a60);
        a240 = gf_mul(a120, a120);
        a252 = gf_mul(a240, a12);
        return gf_mul(a252, a2);
    endfunction

    // Rotate a byte left.
    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    // S-box affine output stage.
    function automatic logic [7:0] sbox_affine(input logic [7:0] b);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_ks_sbox.sv
// One forward AES S-box, computed as field inverse then affine map.
// Purely combinational; assumes nothing about its input.
module aes_ks_sbox
    import aes_ks_pkg::*;
(
    input  logic [KS_BYTE_W-1:0] in_b,
    output logic [KS_BYTE_W-1:0] out_b
);

    // Substitute one byte.
    always_comb begin
        out_b = sbox_affine(gf_inv(in_b));
    end

endmodule

// File: rtl/aes_ks_subword.sv
// Applies the S-box to each byte of a word. Combinational.
module aes_ks_subword
    import aes_ks_pkg::*;
(
    input  logic [KS_WORD_W-1:0] in_w,
    output logic [KS_WORD_W-1:0] out_w
);

    localparam int NBYTES = KS_WORD_W / KS_BYTE_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        aes_ks_sbox u_sbox (
            .in_b  (in_w[g*KS_BYTE_W +: KS_BYTE_W]),
            .out_b (out_w[g*KS_BYTE_W +: KS_BYTE_W])
        );
    end

endmodule

// File: rtl/aes_ks_seq.sv
// Word generator: latches key and size on an accepted start and produces one
// schedule word per cycle from an eight-word history window. It presents the
// words registered, and pulses done the cycle after the last one.
// Assumes start is ignored while busy and that size code 3 is never accepted.
module aes_ks_seq
    import aes_ks_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           key_size,
    input  logic [KS_KEY_W-1:0]  key,
    output logic                 start_acc_o,
    output logic                 step_o,
    output logic [KS_IDX_W-1:0]  step_idx_o,
    output logic [KS_WORD_W-1:0] step_word_o,
    output logic [1:0]           size_o,
    output logic                 out_valid_o,
    output logic [KS_IDX_W-1:0]  out_idx_o,
    output logic [KS_WORD_W-1:0] out_word_o,
    output logic                 done_o
);

    logic                 busy_q;
    logic [KS_IDX_W-1:0]  idx_q;
    logic [KS_PH_W-1:0]   ph_q;
    logic [7:0]           rcon_q;
    logic [KS_KEY_W-1:0]  key_q;
    logic [1:0]           size_q;
    logic [KS_WORD_W-1:0] win_q [KS_MAX_NK];
    logic [KS_WORD_W-1:0] key_w [KS_MAX_NK];
    logic                 out_valid_q;
    logic [KS_IDX_W-1:0]  out_idx_q;
    logic [KS_WORD_W-1:0] out_word_q;
    logic                 done_q;

    logic                 start_acc;
    logic [KS_IDX_W-1:0]  nk_c;
    logic [KS_IDX_W-1:0]  nk_m1;
    logic [KS_IDX_W-1:0]  last_c;
    logic                 in_key;
    logic                 rot_now;
    logic                 sub_extra;
    logic [KS_WORD_W-1:0] prev_w;
    logic [KS_WORD_W-1:0] back_w;
    logic [KS_WORD_W-1:0] sub_in;
    logic [KS_WORD_W-1:0] sub_out;
    logic [KS_WORD_W-1:0] temp_w;
    logic [KS_WORD_W-1:0] new_w;
    logic [KS_PH_W-1:0]   ph_nx;

    // Split the latched key into words, most significant first.
    for (genvar g = 0; g < KS_MAX_NK; g++) begin : g_keyw
        assign key_w[g] = key_q[KS_KEY_W-1-g*KS_WORD_W -: KS_WORD_W];
    end

    // Accept a request only when idle and with a legal size code.
    always_comb begin
        start_acc = start && !busy_q && (key_size != KSZ_BAD);
    end

    // Derive the per-size limits from the latched size.
    always_comb begin
        nk_c   = ks_nk(size_q);
        nk_m1  = nk_c - KS_IDX_W'(1);
        last_c = ks_total(size_q) - KS_IDX_W'(1);
        in_key = idx_q < nk_c;
    end

    // Select the operands and build the mixing term.
    always_comb begin
        prev_w    = win_q[0];
        back_w    = win_q[nk_m1[KS_PH_W-1:0]];
        rot_now   = (ph_q == '0);
        sub_extra = (size_q == KSZ_256) && (ph_q == KS_PH_W'(4));
        sub_in    = rot_now ? {prev_w[KS_WORD_W-KS_BYTE_W-1:0], prev_w[KS_WORD_W-1 -: KS_BYTE_W]}
                            : prev_w;
        if (rot_now)
            temp_w = sub_out ^ {rcon_q, {(KS_WORD_W-KS_BYTE_W){1'b0}}};
        else if (sub_extra)
            temp_w = sub_out;
        else
            temp_w = prev_w;
    end

    aes_ks_subword u_subword (
        .in_w  (sub_in),
        .out_w (sub_out)
    );

    // Pick a key word or a derived word.
    always_comb begin
        new_w = in_key ? key_w[idx_q[KS_PH_W-1:0]] : (back_w ^ temp_w);
        ph_nx = (ph_q == nk_m1[KS_PH_W-1:0]) ? '0 : ph_q + KS_PH_W'(1);
    end

    // Advance the expansion and register the stream outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            idx_q       <= '0;
            ph_q        <= '0;
            rcon_q      <= 8'h01;
            key_q       <= '0;
            size_q      <= KSZ_128;
            out_valid_q <= 1'b0;
            out_idx_q   <= '0;
            out_word_q  <= '0;
            done_q      <= 1'b0;
            for (int k = 0; k < KS_MAX_NK; k++) win_q[k] <= '0;
        end else begin
            out_valid_q <= 1'b0;
            done_q      <= out_valid_q && (out_idx_q == last_c);
            if (start_acc) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                ph_q   <= '0;
                rcon_q <= 8'h01;
                key_q  <= key;
                size_q <= key_size;
            end else if (busy_q) begin
                out_valid_q <= 1'b1;
                out_word_q  <= new_w;
                out_idx_q   <= idx_q;
                for (int k = KS_MAX_NK - 1; k > 0; k--) win_q[k] <= win_q[k-1];
                win_q[0]    <= new_w;
                idx_q       <= idx_q + KS_IDX_W'(1);
                ph_q        <= ph_nx;
                if (!in_key && rot_now) rcon_q <= gf_xtime(rcon_q);
                if (idx_q == last_c) busy_q <= 1'b0;
            end
        end
    end

    assign start_acc_o = start_acc;
    assign step_o      = busy_q;
    assign step_idx_o  = idx_q;
    assign step_word_o = new_w;
    assign size_o      = size_q;
    assign out_valid_o = out_valid_q;
    assign out_idx_o   = out_idx_q;
    assign out_word_o  = out_word_q;
    assign done_o      = done_q;

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_q && $past(out_valid_q)) |-> (out_idx_q == $past(out_idx_q) + KS_IDX_W'(1))); // R6
    AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_q) |-> (out_idx_q == '0)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!out_valid_q && $past(out_valid_q))); // R7
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (size_q != KSZ_BAD)); // R1
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> ($stable(key_q) && $stable(size_q))); // R9

endmodule

// File: rtl/aes_ks_dkey.sv
// Decryption-key capture: watches the words as they are generated and stores
// the trailing ones into eight slots in the size-dependent order. The last
// four words go to slots 0..3; for longer keys the Nk-4 words before them go
// to slots 4 onward. Assumes the clear and the capture never coincide.
module aes_ks_dkey
    import aes_ks_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step,
    input  logic [KS_IDX_W-1:0]  step_idx,
    input  logic [KS_WORD_W-1:0] step_word,
    input  logic [1:0]           size,
    output logic [KS_KEY_W-1:0]  dec_key
);

    localparam int SLOT_W = $clog2(KS_SLOTS);

    logic [KS_WORD_W-1:0] slot_q [KS_SLOTS];
    logic [KS_IDX_W-1:0]  total_c;
    logic [KS_IDX_W-1:0]  lead_base;
    logic [KS_IDX_W-1:0]  tail_base;
    logic [KS_IDX_W-1:0]  diff;
    logic                 hit;
    logic [SLOT_W-1:0]    slot_sel;

    // Map a word index to its slot, if it belongs to the key.
    always_comb begin
        total_c   = ks_total(size);
        lead_base = total_c - KS_IDX_W'(KS_LEAD);
        tail_base = total_c - ks_nk(size);
        hit       = 1'b0;
        diff      = '0;
        if (step_idx >= lead_base) begin
            hit  = 1'b1;
            diff = step_idx - lead_base;
        end else if (step_idx >= tail_base) begin
            hit  = 1'b1;
            diff = step_idx - tail_base + KS_IDX_W'(KS_LEAD);
        end
        slot_sel = diff[SLOT_W-1:0];
    end

    for (genvar s = 0; s < KS_SLOTS; s++) begin : g_slot
        // Hold one 32-bit slot: cleared on start, written on a matching word.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                slot_q[s] <= '0;
            else if (step && hit && (slot_sel == SLOT_W'(s)))
                slot_q[s] <= step_word;
        end
        assign dec_key[KS_KEY_W-1-s*KS_WORD_W -: KS_WORD_W] = slot_q[s];
    end

    AST_DK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (dec_key == '0)); // R8
    AST_DK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(dec_key)); // R8

endmodule

// File: rtl/aes_key_sched.sv
// Top of the key schedule unit: the word generator feeding the stream port
// and the decryption-key capture. Synchronous active-low reset.
module aes_key_sched
    import aes_ks_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           key_size,
    input  logic [KS_KEY_W-1:0]  key,
    output logic                 ks_valid,
    output logic [KS_IDX_W-1:0]  ks_index,
    output logic [KS_WORD_W-1:0] ks_word,
    output logic [KS_KEY_W-1:0]  dec_key,
    output logic                 done
);

    logic                 start_acc;
    logic                 step;
    logic [KS_IDX_W-1:0]  step_idx;
    logic [KS_WORD_W-1:0] step_word;
    logic [1:0]           size_q;

    aes_ks_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .key_size    (key_size),
        .key         (key),
        .start_acc_o (start_acc),
        .step_o      (step),
        .step_idx_o  (step_idx),
        .step_word_o (step_word),
        .size_o      (size_q),
        .out_valid_o (ks_valid),
        .out_idx_o   (ks_index),
        .out_word_o  (ks_word),
        .done_o      (done)
    );

    aes_ks_dkey u_dkey (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_acc),
        .step      (step),
        .step_idx  (step_idx),
        .step_word (step_word),
        .size      (size_q),
        .dec_key   (dec_key)
    );

    AST_NO_WORD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ks_valid); // R7

endmodule

// File: tb/aes_key_sched_tb.sv
`timescale 1ns/1ps
module aes_key_sched_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   key_size = 2'd0;
    logic [255:0] key = '0;
    logic         ks_valid;
    logic [5:0]   ks_index;
    logic [31:0]  ks_word;
    logic [255:0] dec_key;
    logic         done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0]  sb [256];
    logic [31:0] ref_w [60];

    // Stimulus table: {size code, key}
    localparam logic [257:0] VEC [6] = '{
        {2'd0, 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0},
        {2'd1, 192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0},
        {2'd2, 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4},
        {2'd0, 256'h0},
        {2'd2, {256{1'b1}}},
        {2'd1, 192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'hdeadbeefcafef00d}
    };

    always #2.5 clk = ~clk;

    aes_key_sched dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .key_size(key_size), .key(key),
        .ks_valid(ks_valid), .ks_index(ks_index), .ks_word(ks_word),
        .dec_key(dec_key), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // S-box table from the generator-3 log walk.
    task automatic build_sbox();
        logic [7:0] p, q, t;
        p = 8'h01; q = 8'h01;
        for (int n = 0; n < 255; n++) begin
            t = p;
            p = t ^ (t << 1) ^ (t[7] ? 8'h1B : 8'h00);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            t = q ^ ((q << 1) | (q >> 7)) ^ ((q << 2) | (q >> 6))
                  ^ ((q << 3) | (q >> 5)) ^ ((q << 4) | (q >> 4));
            sb[p] = t ^ 8'h63;
        end
        sb[0] = 8'h63;
    endtask

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    function automatic int nk_of(input logic [1:0] s);
        return (s == 2'd0) ? 4 : (s == 2'd1) ? 6 : 8;
    endfunction

    // Reference expansion (R2..R5).
    task automatic ref_expand(input logic [1:0] s, input logic [255:0] k);
        int nk;
        logic [31:0] t;
        logic [7:0] rc;
        nk = nk_of(s);
        rc = 8'h01;
        for (int i = 0; i < 4 * (nk + 7); i++) begin
            if (i < nk) ref_w[i] = k[255 - 32*i -: 32];
            else begin
                t = ref_w[i-1];
                if (i % nk == 0) begin
                    t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                    rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1B : 8'h00);
                end else if (nk == 8 && i % 8 == 4) t = subw(t);
                ref_w[i] = ref_w[i-nk] ^ t;
            end
        end
    endtask

    function automatic logic [255:0] exp_dk(input logic [1:0] s);
        case (s)
            2'd0:    return {ref_w[40], ref_w[41], ref_w[42], ref_w[43], 128'h0};
            2'd1:    return {ref_w[48], ref_w[49], ref_w[50], ref_w[51], ref_w[46], ref_w[47], 64'h0};
            default: return {ref_w[56], ref_w[57], ref_w[58], ref_w[59],
                             ref_w[52], ref_w[53], ref_w[54], ref_w[55]};
        endcase
    endfunction

    // One expansion; called at a falling edge. disturb pokes start mid-run (R9).
    task automatic run_one(input logic [1:0] s, input logic [255:0] k, input bit disturb);
        int total;
        total = 4 * (nk_of(s) + 7);
        ref_expand(s, k);
        start = 1'b1; key_size = s; key = k;
        @(negedge clk);
        start = 1'b0;
        chk(!ks_valid, "R6 no word before first edge", {255'h0, ks_valid}, 256'h0);
        for (int n = 0; n < total; n++) begin
            @(negedge clk);
            chk(ks_valid && ks_index == n[5:0] && ks_word == ref_w[n],
                "R1 R2 R3 R4 R5 R6 stream word",
                {215'h0, ks_valid, ks_index, ks_word}, {215'h0, 1'b1, n[5:0], ref_w[n]});
            if (disturb && n == 5) begin start = 1'b1; key_size = 2'd0; key = ~k; end
            if (disturb && n == 6) start = 1'b0;
        end
        @(negedge clk);
        chk(done && !ks_valid, "R7 done after last word", {254'h0, done, ks_valid}, 256'h2);
        chk(dec_key == exp_dk(s), "R8 decryption key", dec_key, exp_dk(s));
        @(negedge clk);
        chk(!done, "R7 done one cycle", {255'h0, done}, 256'h0);
        if (disturb) begin
            for (int n = 0; n < 3; n++) begin
                @(negedge clk);
                chk(!ks_valid && !done, "R9 no restart from ignored start",
                    {254'h0, ks_valid, done}, 256'h0);
            end
        end
    endtask

    initial begin
        logic [255:0] held;
        build_sbox();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk(!ks_valid && !done, "R10 outputs after reset", {254'h0, ks_valid, done}, 256'h0);
        chk(dec_key == '0, "R10 dec_key after reset", dec_key, 256'h0);
        @(negedge clk);
        // table walk
        for (int v = 0; v < 6; v++) run_one(VEC[v][257:256], VEC[v][255:0], v == 2);
        // known answer for the 128-bit test key (R3)
        run_one(VEC[0][257:256], VEC[0][255:0], 1'b0);
        chk(dec_key[255:224] == 32'hd014f9a8, "R3 known word 40", {224'h0, dec_key[255:224]}, {224'h0, 32'hd014f9a8});
        chk(dec_key[159:128] == 32'hb6630ca6, "R3 known word 43", {224'h0, dec_key[159:128]}, {224'h0, 32'hb6630ca6});
        // R1 size code 3 ignored
        held = dec_key;
        start = 1'b1; key_size = 2'd3; key = ~key;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            chk(!ks_valid && !done, "R1 code 3 produces nothing", {254'h0, ks_valid, done}, 256'h0);
        end
        chk(dec_key == held, "R1 R8 code 3 keeps dec_key", dec_key, held);
        // back-to-back run right after a previous one (R6)
        run_one(2'd2, VEC[4][255:0], 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule